// File: doc/BRIEF.md
# Multi-Cycle Shared-Bus Register Processor

This block is a small sequenced datapath. It has eight general registers, an operand latch, a result latch and an instruction latch. All of them exchange data over one shared bus. A single 16-bit input port `din` carries both instruction words and immediate operands. While `run` is high, a two-bit step counter walks the control unit through up to four steps. Each step enables exactly one bus source and the matching load strobes. Register moves and immediate loads finish in two cycles. Addition and subtraction take four cycles, because they route both operands and the result over the same bus.

The surrounding logic presents an instruction word on `din` in the step where the counter is at zero, with `run` high. For an immediate load it then presents the 16-bit operand on `din` in the following cycle. It waits for `done`, which is high during the last step of the instruction. The bus value is brought out on `bus_out`, so any register can be observed by moving it onto itself.

Top module: `bus_accum_cpu`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the step counter returns to step zero and every register clears to zero: the eight general registers, the operand latch, the result latch and the instruction latch. `done` stays low throughout reset.
- R2: In step zero with `run` high, the instruction latch takes `din[15:7]`. The opcode is in `din[15:13]`, the destination index Rx in `din[12:10]` and the source index Ry in `din[9:7]`. Bits `din[6:0]` have no effect on execution. No source drives the bus in step zero.
- R3: Opcode 000 (move): in step one, `bus_out` carries Ry, Rx is loaded from the bus and `done` is high.
- R4: Opcode 001 (immediate load): in step one, `bus_out` carries the full 16-bit `din`, Rx is loaded from it and `done` is high.
- R5: Opcode 010 (add): step one drives Rx onto the bus, step two drives Ry, and step three drives Rx+Ry modulo 2^16. Rx takes that value and `done` is high only in step three.
- R6: Opcode 011 (subtract): the sequence is the same as for add, and step three drives Rx−Ry modulo 2^16.
- R7: At most one bus source is enabled in any cycle. A cycle with no source enabled drives zero on `bus_out`.
- R8: The step counter advances by one on each edge while `run` is high. It returns to step zero on the edge that ends a cycle with `done` high, so back-to-back instructions need no idle cycle.
- R9: While `run` is low, the step counter holds, no register is loaded, `done` is low and `bus_out` is zero. When `run` rises again, execution resumes at the held step.
- R10: Opcodes 100 to 111 raise `done` in step one, drive nothing onto the bus and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables stepping and all load strobes |
| din | input | 16 | Instruction word in step zero; immediate operand in step one of a load |
| done | output | 1 | High during the final step of an instruction |
| bus_out | output | 16 | Current value on the shared bus |

## Verification
The assertions assume that `run` and `din` are stable around each rising edge, and that reset is applied long enough to be sampled by at least one edge. They also assume that an instruction word is latched in step zero before its later steps are decoded. The bench meets these assumptions by changing every input on the falling edge and sampling two time units later. It always opens an instruction with its word in step zero. It withdraws `run` only at step boundaries, which covers the mid-instruction pause in R9 while leaving the bus and strobe assumptions intact.

// File: rtl/bus_accum_pkg.sv
// Shared opcode and step encodings for the shared-bus processor.
// Assumes a 3-bit opcode and a 2-bit step counter.
package bus_accum_pkg;
    localparam int OPC_W  = 3;
    localparam int STEP_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_MOVE = 3'b000,
        OP_LDI  = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b011
    } opcode_e;

    localparam logic [STEP_W-1:0] STEP_0 = 2'd0;
    localparam logic [STEP_W-1:0] STEP_1 = 2'd1;
    localparam logic [STEP_W-1:0] STEP_2 = 2'd2;
    localparam logic [STEP_W-1:0] STEP_3 = 2'd3;
endpackage

// File: rtl/step_counter.sv
// Step counter: advances once per edge while run is high and returns to
// zero after a done cycle. Assumes a synchronous active-low reset.
module step_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    output logic [W-1:0] step
);
    // Advance, clear or hold the step count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= '0;
        else if (run) begin
            if (clear)
                step <= '0;
            else
                step <= step + {{(W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/step_decoder.sv
// Control decode: maps the step count and latched instruction onto one-hot
// bus source enables and load strobes. All outputs are low while run is low.
// Source index layout: 0..NREG-1 general registers, NREG result latch,
// NREG+1 the din port.
module step_decoder
    import bus_accum_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int IDX_W = 3,
    parameter int IR_W  = OPC_W + 2 * IDX_W,
    parameter int NSRC  = NREG + 2
) (
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    input  logic [IR_W-1:0]   ir_q,
    output logic              ir_ld,
    output logic              a_ld,
    output logic              g_ld,
    output logic              add_sel,
    output logic [NREG-1:0]   reg_ld,
    output logic [NSRC-1:0]   src_sel,
    output logic              done
);
    opcode_e          op;
    logic [IDX_W-1:0] rx;
    logic [IDX_W-1:0] ry;

    assign op = opcode_e'(ir_q[IR_W-1 -: OPC_W]);
    assign rx = ir_q[2*IDX_W-1:IDX_W];
    assign ry = ir_q[IDX_W-1:0];

    // Derive this step's strobes from opcode and step.
    always_comb begin
        ir_ld   = 1'b0;
        a_ld    = 1'b0;
        g_ld    = 1'b0;
        add_sel = 1'b0;
        reg_ld  = '0;
        src_sel = '0;
        done    = 1'b0;
        if (run) begin
            case (step)
                STEP_0: ir_ld = 1'b1;
                STEP_1: begin
                    case (op)
                        OP_MOVE: begin
                            src_sel[ry] = 1'b1;
                            reg_ld[rx]  = 1'b1;
                            done        = 1'b1;
                        end
                        OP_LDI: begin
                            src_sel[NREG+1] = 1'b1;
                            reg_ld[rx]      = 1'b1;
                            done            = 1'b1;
                        end
                        OP_ADD, OP_SUB: begin
                            src_sel[rx] = 1'b1;
                            a_ld        = 1'b1;
                        end
                        default: done = 1'b1;
                    endcase
                end
                STEP_2: begin
                    if (op == OP_ADD || op == OP_SUB) begin
                        src_sel[ry] = 1'b1;
                        g_ld        = 1'b1;
                        add_sel     = (op == OP_ADD);
                    end
                end
                default: begin
                    if (op == OP_ADD || op == OP_SUB) begin
                        src_sel[NREG] = 1'b1;
                        reg_ld[rx]    = 1'b1;
                        done          = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bus_select.sv
// One-hot AND-OR bus multiplexer. Assumes at most one enable is set;
// with none set the bus is zero.
module bus_select #(
    parameter int DW   = 16,
    parameter int NSRC = 10
) (
    input  logic [NSRC-1:0][DW-1:0] src,
    input  logic [NSRC-1:0]         sel,
    output logic [DW-1:0]           bus
);
    // OR together each source gated by its enable.
    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++)
            bus = bus | (src[i] & {DW{sel[i]}});
    end
endmodule

// File: rtl/gp_reg_bank.sv
// Bank of general registers. Each register loads the shared bus when its
// own strobe is high. Assumes a synchronous active-low reset.
module gp_reg_bank #(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0]         ld,
    input  logic [DW-1:0]           d,
    output logic [NREG-1:0][DW-1:0] q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold or load one general register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= '0;
            else if (ld[g])
                q[g] <= d;
        end
    end
endmodule

// File: rtl/bus_accum_cpu.sv
// Top level of the shared-bus processor. Latches the instruction word, the
// operand latch A and the result latch G, and wires counter, decode, bus
// and register bank together. Assumes DATA_W >= instruction width.
module bus_accum_cpu
    import bus_accum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] din,
    output logic              done,
    output logic [DATA_W-1:0] bus_out
);
    localparam int IDX_W = $clog2(NREG);
    localparam int IR_W  = OPC_W + 2 * IDX_W;
    localparam int NSRC  = NREG + 2;

    logic [STEP_W-1:0]           step;
    logic [IR_W-1:0]             ir_q;
    logic [DATA_W-1:0]           a_q;
    logic [DATA_W-1:0]           g_q;
    logic [DATA_W-1:0]           alu_y;
    logic [NREG-1:0][DATA_W-1:0] reg_q;
    logic [NSRC-1:0][DATA_W-1:0] src_vec;
    logic [NSRC-1:0]             src_sel;
    logic [NREG-1:0]             reg_ld;
    logic                        ir_ld;
    logic                        a_ld;
    logic                        g_ld;
    logic                        add_sel;

    step_counter #(.W(STEP_W)) u_step (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(done), .step(step)
    );

    step_decoder #(.NREG(NREG), .IDX_W(IDX_W), .IR_W(IR_W), .NSRC(NSRC)) u_dec (
        .run(run), .step(step), .ir_q(ir_q), .ir_ld(ir_ld), .a_ld(a_ld),
        .g_ld(g_ld), .add_sel(add_sel), .reg_ld(reg_ld), .src_sel(src_sel),
        .done(done)
    );

    assign src_vec = {din, g_q, reg_q};

    bus_select #(.DW(DATA_W), .NSRC(NSRC)) u_bus (
        .src(src_vec), .sel(src_sel), .bus(bus_out)
    );

    gp_reg_bank #(.DW(DATA_W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .ld(reg_ld), .d(bus_out), .q(reg_q)
    );

    // Adder/subtractor: add when add_sel is high, else subtract; wraps.
    assign alu_y = add_sel ? (a_q + bus_out) : (a_q - bus_out);

    // Instruction, operand and result latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            a_q  <= '0;
            g_q  <= '0;
        end else begin
            if (ir_ld) ir_q <= din[DATA_W-1 -: IR_W];
            if (a_ld)  a_q  <= bus_out;
            if (g_ld)  g_q  <= alu_y;
        end
    end
endmodule

// File: rtl/bus_accum_cpu_chk.sv
// Property checker for the shared-bus processor, bound into the top.
module bus_accum_cpu_chk #(
    parameter int NREG = 8,
    parameter int IR_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            done,
    input logic [1:0]      step,
    input logic [IR_W-1:0] ir_q,
    input logic [NREG+1:0] src_sel,
    input logic [NREG-1:0] reg_ld,
    input logic            ir_ld,
    input logic            a_ld,
    input logic            g_ld
);
    logic long_op;
    assign long_op = (ir_q[IR_W-1 -: 3] == 3'b010) || (ir_q[IR_W-1 -: 3] == 3'b011);

    // R1
    reset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (step == 2'd0 && !done));
    // R7
    bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_sel));
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (step == 2'd0));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(step));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (reg_ld == '0 && !ir_ld && !a_ld && !g_ld && !done && src_sel == '0));
    // R3
    short_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == 2'd1 && !long_op) |-> done);
    // R5
    long_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == 2'd3) |-> done);
endmodule

bind bus_accum_cpu bus_accum_cpu_chk #(.NREG(NREG), .IR_W(IR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .done(done), .step(step),
    .ir_q(ir_q), .src_sel(src_sel), .reg_ld(reg_ld), .ir_ld(ir_ld),
    .a_ld(a_ld), .g_ld(g_ld)
);

// File: tb/bus_accum_cpu_test.sv
// Directed bench: one task per scenario, each checking its own results.
module bus_accum_cpu_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] din = '0;
    logic        done;
    logic [15:0] bus_out;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [8];

    bus_accum_cpu uut (
        .clk(clk), .rst_n(rst_n), .run(run), .din(din),
        .done(done), .bus_out(bus_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] rx,
                                        input logic [2:0] ry, input logic [6:0] junk);
        return {op, rx, ry, junk};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then settle before sampling.
    task automatic tick(input logic r, input logic [15:0] d);
        @(negedge clk);
        run = r;
        din = d;
        #2;
    endtask

    task automatic read_reg(input int i, input string req);
        tick(1'b1, enc(3'b000, 3'(i), 3'(i), 7'h00));
        tick(1'b1, 16'h0);
        chk(req, bus_out, model[i]);
        chk({req, " done"}, {15'h0, done}, 16'h1);
    endtask

    task automatic load_imm(input int i, input logic [15:0] v);
        tick(1'b1, enc(3'b001, 3'(i), 3'd0, 7'h00));
        chk("R2 step0 bus zero", bus_out, 16'h0);
        chk("R2 step0 done low", {15'h0, done}, 16'h0);
        tick(1'b1, v);
        chk("R4 imm on bus", bus_out, v);
        chk("R4 done", {15'h0, done}, 16'h1);
        model[i] = v;
    endtask

    task automatic arith(input logic sub, input int x, input int y, input string req);
        logic [15:0] res;
        res = sub ? model[x] - model[y] : model[x] + model[y];
        tick(1'b1, enc(sub ? 3'b011 : 3'b010, 3'(x), 3'(y), 7'h00));
        chk({req, " step0 bus"}, bus_out, 16'h0);
        tick(1'b1, 16'h0);
        chk({req, " step1 Rx"}, bus_out, model[x]);
        chk({req, " step1 done low"}, {15'h0, done}, 16'h0);
        tick(1'b1, 16'h0);
        chk({req, " step2 Ry"}, bus_out, model[y]);
        tick(1'b1, 16'h0);
        chk({req, " step3 result"}, bus_out, res);
        chk({req, " step3 done"}, {15'h0, done}, 16'h1);
        model[x] = res;
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        run = 1'b1;
        repeat (3) begin
            tick(1'b1, enc(3'b001, 3'd0, 3'd0, 7'h00));
            chk("R1 done low in reset", {15'h0, done}, 16'h0);
        end
        tick(1'b0, 16'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = '0;
        for (int i = 0; i < 8; i++) read_reg(i, "R1 reg cleared");
    endtask

    task automatic test_loads;
        for (int i = 0; i < 8; i++) load_imm(i, 16'h1111 * 16'(i + 1) ^ 16'h00A5);
        for (int i = 0; i < 8; i++) read_reg(i, "R4 reg value");
    endtask

    task automatic test_move;
        tick(1'b1, enc(3'b000, 3'd2, 3'd5, 7'h7F));
        tick(1'b1, 16'hFFFF);
        chk("R3 Ry on bus", bus_out, model[5]);
        chk("R7 single source", bus_out, model[5]);
        chk("R3 done", {15'h0, done}, 16'h1);
        model[2] = model[5];
        read_reg(2, "R3 Rx updated");
        read_reg(5, "R3 Ry unchanged");
        read_reg(0, "R2 low bits ignored");
    endtask

    task automatic test_arith;
        load_imm(1, 16'hFFF0);
        load_imm(2, 16'h0020);
        arith(1'b0, 1, 2, "R5 add wrap");
        read_reg(1, "R8 after add");
        load_imm(3, 16'h0005);
        load_imm(4, 16'h0007);
        arith(1'b1, 3, 4, "R6 sub wrap");
        read_reg(3, "R6 result");
        arith(1'b0, 6, 6, "R5 self add");
        arith(1'b1, 7, 7, "R6 self sub");
        read_reg(6, "R5 self result");
        read_reg(7, "R6 zero result");
    endtask

    task automatic test_pause;
        logic [15:0] res;
        res = model[0] + model[5];
        tick(1'b1, enc(3'b010, 3'd0, 3'd5, 7'h00));
        tick(1'b1, 16'h0);
        chk("R9 pre-pause Rx", bus_out, model[0]);
        repeat (3) begin
            tick(1'b0, enc(3'b001, 3'd0, 3'd0, 7'h00));
            chk("R9 paused bus zero", bus_out, 16'h0);
            chk("R9 paused done low", {15'h0, done}, 16'h0);
        end
        tick(1'b1, 16'h0);
        chk("R9 resume at step2", bus_out, model[5]);
        tick(1'b1, 16'h0);
        chk("R9 resumed result", bus_out, res);
        chk("R9 resumed done", {15'h0, done}, 16'h1);
        model[0] = res;
        read_reg(0, "R9 final value");
    endtask

    task automatic test_nop;
        for (int op = 4; op < 8; op++) begin
            tick(1'b1, enc(3'(op), 3'd1, 3'd2, 7'h00));
            tick(1'b1, 16'hBEEF);
            chk("R10 no bus source", bus_out, 16'h0);
            chk("R10 done", {15'h0, done}, 16'h1);
        end
        read_reg(1, "R10 Rx unchanged");
        read_reg(2, "R10 Ry unchanged");
    endtask

    initial begin
        test_reset;
        test_loads;
        test_move;
        test_arith;
        test_pause;
        test_nop;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule